// File: doc/BRIEF.md
# DMA Request Router with Periodic Gating

The block steers one of 64 peripheral request lines onto each of 16 DMA request outputs. Every output channel owns an 8-bit configuration word that enables the channel, chooses its source and, on the lowest four channels, turns on periodic gating. In gated mode a source request reaches the DMA engine only when it meets a pulse from a periodic timer in the same cycle. The request is then held until the engine acknowledges that channel. The block also routes each channel acknowledge back to the source that channel currently owns.

Some source numbers are dead and leave their channel silent. The top ten source numbers are tied permanently active. If one of these drives a gated channel, the timer alone paces the transfers. When two channels select the same real source, only the lower-numbered channel receives it. Software is expected to clear a channel's word before giving it a new source or mode. The block enforces this rule by dropping any write that changes either field while the channel stays enabled.

Top module: `dma_req_router`

## Requirements
- R1: After reset every channel is disabled, and both `dma_req` and `src_ack` are all zero, whatever `src_req` carries.
- R2: A configuration word is written through `cfg_wr`/`cfg_sel`/`cfg_data` and takes effect on the cycle after the write edge. Bit 7 is enable, bit 6 selects gated mode, and bits 5:0 are the source number. With bit 7 clear the channel output is low.
- R3: Source numbers 0, 1, 16, 17 and 38 are void: a channel enabled with one of them keeps its output low.
- R4: In normal mode (bit 6 clear), `dma_req[c]` follows `src_req[source]` in the same cycle with no register in the path.
- R5: In gated mode on channels 0 to 3, a request is captured only when `trig_pulse[c]` and the selected source request are high in the same cycle. `dma_req[c]` rises on the following cycle. A source request without a pulse produces nothing.
- R6: A trigger pulse that arrives while the selected source request is low is discarded and leaves no pending request behind.
- R7: A captured gated request stays high until `dma_ack[c]`, and drops on the cycle after the acknowledge. If a new pulse-and-request coincidence falls in the acknowledge cycle, the request stays high.
- R8: Source numbers 54 to 63 are always active. In normal mode they hold the output high. In gated mode they produce one held request per trigger pulse.
- R9: On channels 4 to 15 the mode bit and `trig_pulse` have no effect, and the channel behaves as in normal mode.
- R10: A write that leaves an enabled channel enabled but changes its source or mode bit is dropped. A write that clears enable is always accepted, and it drops a pending gated request at once.
- R11: If several enabled channels select the same source below 54, only the lowest-numbered one receives its request. The others stay low.
- R12: `src_ack[s]` is high while the channel that owns source s has `dma_ack` high. Bits 54 to 63 of `src_ack` are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Channel addressed by the write |
| cfg_data | input | 8 | Configuration word: enable, gated mode, source |
| src_req | input | 64 | Peripheral request lines, one per source number |
| trig_pulse | input | 16 | Periodic timer pulse per channel |
| dma_ack | input | 16 | DMA engine acknowledge per channel |
| dma_req | output | 16 | Request to the DMA engine per channel |
| src_ack | output | 64 | Acknowledge returned to each source |

## Verification
The bench fires a trigger with no request pending, then a request later on its own. A design that latched either half would issue a spurious transfer. It lets an acknowledge coincide with a fresh coincidence, which catches a clear that wins over a set and loses a transfer. It also clears enable while a request is held, to catch a request that leaks through suspension. It sets two channels on one source and watches where the acknowledge goes, because an arbiter that picks the wrong owner, or an acknowledge that reaches an always-active source, shows up directly on `dma_req` and `src_ack`. Rejected mid-run writes are checked by observing that the old source still drives the channel.

// File: rtl/drr_pkg.sv
package drr_pkg;
  localparam int SRC_W     = 6;
  localparam int NUM_SRC   = 1 << SRC_W;
  localparam int CONST_LO  = 54;

  typedef struct packed {
    logic             en;
    logic             gated;
    logic [SRC_W-1:0] src;
  } chan_cfg_t;

  function automatic logic src_is_void(input logic [SRC_W-1:0] s);
    return (s == 6'd0) || (s == 6'd1) || (s == 6'd16) ||
           (s == 6'd17) || (s == 6'd38);
  endfunction

  function automatic logic src_is_const(input logic [SRC_W-1:0] s);
    return int'(s) >= CONST_LO;
  endfunction
endpackage

// File: rtl/drr_rst_sync.sv
module drr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stg1_q;
  logic stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_q_n = stg2_q;
endmodule

// File: rtl/drr_cfg_bank.sv
module drr_cfg_bank #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_i,
  input  logic [CH_W-1:0]                   sel_i,
  input  drr_pkg::chan_cfg_t                wdata_i,
  output drr_pkg::chan_cfg_t [NUM_CH-1:0]   cfg_o
);
  drr_pkg::chan_cfg_t [NUM_CH-1:0] cfg_q;
  drr_pkg::chan_cfg_t [NUM_CH-1:0] cfg_d;
  drr_pkg::chan_cfg_t              cur;
  logic                            reject;
  logic                            upd;

  // Next-state: a live channel may only be rewritten with the same fields
  // or have its enable cleared.
  always_comb begin
    cfg_d  = cfg_q;
    cur    = cfg_q[sel_i];
    reject = cur.en && wdata_i.en &&
             ((cur.gated != wdata_i.gated) || (cur.src != wdata_i.src));
    upd    = wr_i && (int'(sel_i) < NUM_CH) && !reject;
    if (upd) cfg_d[sel_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (upd) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/drr_route.sv
module drr_route #(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG_CH = 4
) (
  input  drr_pkg::chan_cfg_t [NUM_CH-1:0] cfg_i,
  input  logic [drr_pkg::NUM_SRC-1:0]     src_req_i,
  input  logic [NUM_CH-1:0]               dma_ack_i,
  output logic [NUM_CH-1:0]               live_req_o,
  output logic [NUM_TRIG_CH-1:0]          gated_mode_o,
  output logic [drr_pkg::NUM_SRC-1:0]     src_ack_o
);
  logic [NUM_CH-1:0] live_en;
  logic [NUM_CH-1:0] claims;
  logic [NUM_CH-1:0] owns;
  logic              unused_hi_mode;

  // Channel qualification and ownership of real sources.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      live_en[c] = cfg_i[c].en && !drr_pkg::src_is_void(cfg_i[c].src);
      claims[c]  = live_en[c] && !drr_pkg::src_is_const(cfg_i[c].src);
    end
    for (int c = 0; c < NUM_CH; c++) begin
      owns[c] = claims[c];
      for (int j = 0; j < NUM_CH; j++) begin
        if (j < c && claims[j] && (cfg_i[j].src == cfg_i[c].src)) owns[c] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      live_req_o[c] = live_en[c] &&
                      (drr_pkg::src_is_const(cfg_i[c].src) ||
                       (owns[c] && src_req_i[cfg_i[c].src]));
    end
    for (int c = 0; c < NUM_TRIG_CH; c++) begin
      gated_mode_o[c] = live_en[c] && cfg_i[c].gated;
    end
  end

  always_comb begin
    unused_hi_mode = 1'b0;
    for (int c = NUM_TRIG_CH; c < NUM_CH; c++) begin
      unused_hi_mode = unused_hi_mode ^ cfg_i[c].gated;
    end
  end

  // Acknowledge returns only to the owner's source.
  always_comb begin
    src_ack_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (owns[c] && dma_ack_i[c]) src_ack_o[cfg_i[c].src] = 1'b1;
    end
  end
endmodule

// File: rtl/drr_trig_gate.sv
module drr_trig_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic pulse_i,
  input  logic req_i,
  input  logic ack_i,
  output logic req_o
);
  logic hold_q;
  logic hold_d;
  logic hold_upd;

  always_comb begin
    hold_upd = (pulse_i && req_i) || ack_i || !mode_i;
    hold_d   = mode_i && ((hold_q && !ack_i) || (pulse_i && req_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (hold_upd) begin
      hold_q <= hold_d;
    end
  end

  assign req_o = mode_i && hold_q;
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG_CH = 4,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int NSRC       = drr_pkg::NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CH_W-1:0]   cfg_sel,
  input  logic [7:0]        cfg_data,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NUM_CH-1:0] trig_pulse,
  input  logic [NUM_CH-1:0] dma_ack,
  output logic [NUM_CH-1:0] dma_req,
  output logic [NSRC-1:0]   src_ack
);
  logic                            rst_q_n;
  drr_pkg::chan_cfg_t [NUM_CH-1:0] cfg_q;
  logic [NUM_CH-1:0]               live_req;
  logic [NUM_TRIG_CH-1:0]          gated_mode;
  logic [NUM_TRIG_CH-1:0]          gated_req;
  logic                            unused_hi_pulse;

  drr_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  drr_cfg_bank #(.NUM_CH(NUM_CH)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_i    (cfg_wr),
    .sel_i   (cfg_sel),
    .wdata_i (drr_pkg::chan_cfg_t'(cfg_data)),
    .cfg_o   (cfg_q)
  );

  drr_route #(.NUM_CH(NUM_CH), .NUM_TRIG_CH(NUM_TRIG_CH)) u_route (
    .cfg_i        (cfg_q),
    .src_req_i    (src_req),
    .dma_ack_i    (dma_ack),
    .live_req_o   (live_req),
    .gated_mode_o (gated_mode),
    .src_ack_o    (src_ack)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c < NUM_TRIG_CH) begin : g_gated
      drr_trig_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .mode_i  (gated_mode[c]),
        .pulse_i (trig_pulse[c]),
        .req_i   (live_req[c]),
        .ack_i   (dma_ack[c]),
        .req_o   (gated_req[c])
      );
      assign dma_req[c] = gated_mode[c] ? gated_req[c] : live_req[c];
    end else begin : g_plain
      assign dma_req[c] = live_req[c];
    end
  end

  assign unused_hi_pulse = ^trig_pulse[NUM_CH-1:NUM_TRIG_CH];
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk #(
  parameter int NUM_CH      = 16,
  parameter int NUM_TRIG_CH = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input drr_pkg::chan_cfg_t [NUM_CH-1:0] cfg_q,
  input logic [NUM_CH-1:0]               trig_pulse,
  input logic [NUM_CH-1:0]               dma_ack,
  input logic [NUM_CH-1:0]               dma_req,
  input logic [drr_pkg::NUM_SRC-1:0]     src_ack
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_all
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[c].en |-> !dma_req[c]); // R2
    AST_VOID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      drr_pkg::src_is_void(cfg_q[c].src) |-> !dma_req[c]); // R3
    if (c < NUM_TRIG_CH) begin : g_trig
      AST_TRIG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[c].en && cfg_q[c].gated && $past(cfg_q[c].en && cfg_q[c].gated) &&
         $rose(dma_req[c])) |-> $past(trig_pulse[c])); // R5
      AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[c].en && cfg_q[c].gated && dma_req[c] && !dma_ack[c])
        |=> (dma_req[c] || !cfg_q[c].en)); // R7
      AST_TRIG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[c].en && cfg_q[c].gated && dma_ack[c] && !trig_pulse[c])
        |=> !dma_req[c]); // R7
    end
  end

  AST_CONST_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    src_ack[drr_pkg::NUM_SRC-1:drr_pkg::CONST_LO] == '0); // R12
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ack) |-> (|dma_ack)); // R12
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_ack) <= $countones(dma_ack)); // R11
endmodule

bind dma_req_router dma_req_router_chk #(
  .NUM_CH      (NUM_CH),
  .NUM_TRIG_CH (NUM_TRIG_CH)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .cfg_q      (cfg_q),
  .trig_pulse (trig_pulse),
  .dma_ack    (dma_ack),
  .dma_req    (dma_req),
  .src_ack    (src_ack)
);

// File: tb/dma_req_router_tb_top.sv
`timescale 1ns/1ps
module dma_req_router_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [3:0]  cfg_sel;
  logic [7:0]  cfg_data;
  logic [63:0] src_req;
  logic [15:0] trig_pulse;
  logic [15:0] dma_ack;
  logic [15:0] dma_req;
  logic [63:0] src_ack;

  int n_run;
  int n_fail;
  int cyc;
  bit done;

  typedef struct {
    int          due;
    bit          is_ack;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  dma_req_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .src_req(src_req), .trig_pulse(trig_pulse),
    .dma_ack(dma_ack), .dma_req(dma_req), .src_ack(src_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops every item due in this cycle and compares at the falling edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [63:0] got;
      it  = sb_q.pop_front();
      got = it.is_ack ? src_ack : {48'b0, dma_req};
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: %s got %h expected %h", it.tag,
                 it.is_ack ? "src_ack" : "dma_req", got, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic exp_req(input logic [15:0] v, input string tag);
    item_t it;
    it.due = cyc; it.is_ack = 1'b0; it.exp = {48'b0, v}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic exp_ack(input logic [63:0] v, input string tag);
    item_t it;
    it.due = cyc; it.is_ack = 1'b1; it.exp = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_sel = 4'(ch); cfg_data = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc = 0; n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_data = '0;
    src_req = '0; trig_pulse = '0; dma_ack = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R1: quiet after reset even with every source active
    src_req = '1;
    exp_req(16'h0000, "R1"); exp_ack(64'h0, "R1");
    step(); src_req = '0;

    // R4 / R2: plain routing on channel 2, source 2
    wr(2, 8'h82);
    src_req[2] = 1'b1; exp_req(16'h0004, "R4");
    step(); src_req = '0; src_req[5] = 1'b1; exp_req(16'h0000, "R4");
    step(); src_req = '0;
    wr(2, 8'h00);
    src_req[2] = 1'b1; exp_req(16'h0000, "R2");
    step(); src_req = '0;

    // R3: void source numbers
    wr(3, 8'h90);
    src_req[16] = 1'b1; exp_req(16'h0000, "R3");
    step(); src_req = '0;
    wr(3, 8'h00); wr(3, 8'hA6);
    src_req[38] = 1'b1; exp_req(16'h0000, "R3");
    step(); src_req = '0;
    wr(3, 8'h00);

    // R5 / R6 / R7: gated channel 0 on source 18
    wr(0, 8'hD2);
    trig_pulse[0] = 1'b1; exp_req(16'h0000, "R6");
    step(); trig_pulse = '0; exp_req(16'h0000, "R6");
    step(); src_req[18] = 1'b1; exp_req(16'h0000, "R5");
    step(); trig_pulse[0] = 1'b1; exp_req(16'h0000, "R5");
    step(); trig_pulse = '0; src_req = '0; exp_req(16'h0001, "R5");
    step(); exp_req(16'h0001, "R7");
    step(); dma_ack[0] = 1'b1; exp_req(16'h0001, "R7"); exp_ack(64'h1 << 18, "R12");
    step(); dma_ack = '0; exp_req(16'h0000, "R7");
    step(); trig_pulse[0] = 1'b1; src_req[18] = 1'b1;
    step(); trig_pulse = '0; src_req = '0; exp_req(16'h0001, "R5");
    step(); dma_ack[0] = 1'b1; trig_pulse[0] = 1'b1; src_req[18] = 1'b1;
    step(); dma_ack = '0; trig_pulse = '0; src_req = '0; exp_req(16'h0001, "R7");
    step(); dma_ack[0] = 1'b1;
    step(); dma_ack = '0; exp_req(16'h0000, "R7");

    // R10: clearing enable drops a held request
    step(); trig_pulse[0] = 1'b1; src_req[18] = 1'b1;
    step(); trig_pulse = '0; src_req = '0; exp_req(16'h0001, "R5");
    step(); wr(0, 8'h00); exp_req(16'h0000, "R10");
    wr(0, 8'hD2); exp_req(16'h0000, "R10");
    step(); wr(0, 8'h00);

    // R8: always-active source on gated channel 1, then in normal mode
    wr(1, 8'hFF); exp_req(16'h0000, "R8");
    step(); trig_pulse[1] = 1'b1; exp_req(16'h0000, "R8");
    step(); trig_pulse = '0; exp_req(16'h0002, "R8");
    step(); dma_ack[1] = 1'b1; exp_req(16'h0002, "R8"); exp_ack(64'h0, "R12");
    step(); dma_ack = '0; exp_req(16'h0000, "R8");
    step(); exp_req(16'h0000, "R8");
    step(); trig_pulse[1] = 1'b1;
    step(); trig_pulse = '0; exp_req(16'h0002, "R8");
    step(); wr(1, 8'h00);
    wr(1, 8'hBC); exp_req(16'h0002, "R8");
    dma_ack[1] = 1'b1; exp_ack(64'h0, "R12");
    step(); dma_ack = '0; wr(1, 8'h00);

    // R9: mode bit and pulse ignored on channel 5
    wr(5, 8'hCA);
    src_req[10] = 1'b1; exp_req(16'h0020, "R9");
    step(); src_req = '0; trig_pulse[5] = 1'b1; exp_req(16'h0000, "R9");
    step(); trig_pulse = '0; exp_req(16'h0000, "R9");
    step(); trig_pulse[5] = 1'b1; src_req[10] = 1'b1; exp_req(16'h0020, "R9");
    step(); trig_pulse = '0; src_req = '0; exp_req(16'h0000, "R9");
    step(); wr(5, 8'h00);

    // R10: live rewrite of source or mode is dropped
    wr(2, 8'h82); wr(2, 8'h83);
    src_req[3] = 1'b1; exp_req(16'h0000, "R10");
    step(); src_req = '0; src_req[2] = 1'b1; exp_req(16'h0004, "R10");
    step(); src_req = '0;
    wr(2, 8'hC2);
    src_req[2] = 1'b1; exp_req(16'h0004, "R10");
    step(); src_req = '0;
    wr(2, 8'h00); wr(2, 8'h83);
    src_req[3] = 1'b1; exp_req(16'h0004, "R10");
    step(); src_req = '0; wr(2, 8'h00);

    // R11 / R12: two channels on source 20
    wr(6, 8'h94); wr(7, 8'h94);
    src_req[20] = 1'b1; dma_ack[7] = 1'b1;
    exp_req(16'h0040, "R11"); exp_ack(64'h0, "R12");
    step(); dma_ack = '0; dma_ack[6] = 1'b1;
    exp_req(16'h0040, "R11"); exp_ack(64'h1 << 20, "R12");
    step(); dma_ack = '0;
    wr(6, 8'h00); exp_req(16'h0080, "R11");
    dma_ack[7] = 1'b1; exp_ack(64'h1 << 20, "R12");
    step(); dma_ack = '0; src_req = '0; wr(7, 8'h00);

    repeat (3) step();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule